// File: doc/BRIEF.md
# 100 Mb/s Transmit Symbol Encoder

This block sits at the head of a 100 Mb/s transmit path. It takes frame data from a MAC in one of two bus modes. In nibble mode it takes four bits per clock. In reduced mode it takes two bits per clock and pairs them into a nibble. Each nibble is turned into a 5-bit code-group. Frames are opened with a start-delimiter pair and closed with an end-delimiter pair, and the idle code-group fills the gaps between frames. When the MAC flags an error during a data nibble, the error code-group replaces the encoded data.

A control input can switch the block into a raw symbol mode, but only in nibble mode. In that mode the four data bits and the error input pass straight through as a 5-bit symbol, with the error input as the top bit. The output is a registered 5-bit symbol with a strobe that marks each symbol slot. Scrambling and serialisation happen downstream.

Top module: `pcs100_tx_encoder`

## Requirements
- R1: A synchronous active-low reset drives `sym` to idle 11111 and `sym_vld` to 0 on the next clock edge, and clears any half-built nibble.
- R2: In nibble mode (`rmii_sel`=0), every clock is a symbol slot. `sym_vld` is 1 in the cycle after each edge, and `sym` holds the symbol for the inputs sampled at that edge. When no frame is in progress and `mac_txen` is low, the symbol is idle 11111.
- R3: Data nibbles are encoded as 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R4: The first two slots of a frame (enable seen high from idle) carry J 11000 then K 10001 in place of their data. Data encoding starts at the third slot.
- R5: The first slot after the K slot in which enable is low carries T 01101. The next slot carries R 00111, then idle follows. Enable is ignored during the R slot, so a new frame starts with J in the slot after it. A one-slot frame still gives J, K, T, R.
- R6: When `mac_txer` and `speed100` are both high in a data slot, the error symbol 00100 is sent. When `speed100` is low, the error input has no effect.
- R7: In reduced mode (`rmii_sel`=1), only `mac_txd[1:0]` is used. The first dibit of a pair forms nibble bits [1:0] and the second forms bits [3:2]. `sym_vld` pulses every other cycle. `mac_txd[3:2]` and `mac_txer` are ignored. The dibit on the bus while `sym_vld` is high, or in the first cycle after reset, is a first dibit.
- R8: A reset that arrives between the two dibits of a pair discards the first dibit. The first dibit after reset starts a new pair.
- R9: In nibble mode with `enc_en`=0, each slot outputs {`mac_txer`, `mac_txd`} unchanged, with no framing. When `enc_en` returns to 1, the block starts in idle.
- R10: In reduced mode, `enc_en`=0 has no effect and encoding and framing continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: nibble clock in nibble mode, dibit clock in reduced mode |
| rst_n | input | 1 | Synchronous active-low reset |
| rmii_sel | input | 1 | 1 selects the 2-bit reduced bus, 0 the 4-bit nibble bus |
| enc_en | input | 1 | 1 encodes; 0 selects raw symbol pass-through (nibble mode only) |
| speed100 | input | 1 | 1 at 100 Mb/s; 0 masks the error input |
| mac_txd | input | 4 | Transmit data from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| mac_txer | input | 1 | Transmit error from the MAC; top symbol bit in pass-through |
| sym | output | 5 | Registered 5-bit code-group |
| sym_vld | output | 1 | High in each cycle that `sym` carries a new slot |

## Verification
The bench targets the edges of a frame. It checks a one-slot frame, a frame whose enable comes back during the R slot, and a full run of all sixteen data codes. A framer that drops K on short frames, or that restarts on the R slot, sends the wrong delimiter sequence. In reduced mode, the upper bus bits and the error input carry junk on purpose, so a design that fails to mask them emits wrong codes. A reset applied after a lone first dibit exposes a pair counter that is not cleared: later nibbles would be built from dibits of two different pairs. Pass-through is tried in both modes, so a bypass that is not gated by the mode would corrupt reduced-mode frames.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;
  localparam int SYM_W  = 5;
  localparam int NIB_W  = 4;
  localparam int LANE_W = 2;

  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_ERR  = 5'b00100;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_K    = 2'd1,
    FR_DATA = 2'd2,
    FR_R    = 2'd3
  } fr_state_e;

  function automatic logic [SYM_W-1:0] nib_to_sym(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  function automatic logic [SYM_W-1:0] data_sym(input logic [NIB_W-1:0] n,
                                                input logic err);
    return err ? SYM_ERR : nib_to_sym(n);
  endfunction
endpackage

// File: rtl/pcs_tx_lane_pack.sv
module pcs_tx_lane_pack #(
  parameter int IN_W  = 2,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             narrow,
  input  logic [OUT_W-1:0] din,
  output logic [OUT_W-1:0] word,
  output logic             slot
);
  localparam int LANES = OUT_W / IN_W;
  localparam int CW    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [CW-1:0]   cnt;
  logic [IN_W-1:0] hold [LANES-1];
  logic [OUT_W-1:0] word_n;
  logic            last;

  assign last = (cnt == CW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int g = 0; g < LANES - 1; g++) hold[g] <= '0;
    end else if (!narrow) begin
      cnt <= '0;
    end else begin
      for (int g = 0; g < LANES - 1; g++)
        if (cnt == CW'(g)) hold[g] <= din[IN_W-1:0];
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    assign word_n[g*IN_W +: IN_W] = hold[g];
  end
  assign word_n[OUT_W-1 -: IN_W] = din[IN_W-1:0];

  assign word = narrow ? word_n : din;
  assign slot = narrow ? last : 1'b1;
endmodule

// File: rtl/pcs_tx_framer.sv
module pcs_tx_framer
  import pcs_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot,
  input  logic             bypass,
  input  logic             en,
  input  logic             err,
  input  logic [NIB_W-1:0] nib,
  input  logic [SYM_W-1:0] raw,
  output logic [SYM_W-1:0] sym_nxt,
  output logic             frame_start,
  output logic             frame_end
);
  fr_state_e st, st_nxt;
  logic fs, fe;

  always_comb begin
    st_nxt  = st;
    sym_nxt = SYM_IDLE;
    fs      = 1'b0;
    fe      = 1'b0;
    if (bypass) begin
      sym_nxt = raw;
      st_nxt  = FR_IDLE;
    end else begin
      case (st)
        FR_IDLE: if (en) begin
          sym_nxt = SYM_J;
          st_nxt  = FR_K;
          fs      = 1'b1;
        end
        FR_K: begin
          sym_nxt = SYM_K;
          st_nxt  = FR_DATA;
        end
        FR_DATA: if (en) begin
          sym_nxt = data_sym(nib, err);
        end else begin
          sym_nxt = SYM_T;
          st_nxt  = FR_R;
          fe      = 1'b1;
        end
        FR_R: begin
          sym_nxt = SYM_R;
          st_nxt  = FR_IDLE;
        end
        default: st_nxt = FR_IDLE;
      endcase
    end
  end

  assign frame_start = slot & fs;
  assign frame_end   = slot & fe;

  always_ff @(posedge clk) begin
    if (!rst_n)    st <= FR_IDLE;
    else if (slot) st <= st_nxt;
  end
endmodule

// File: rtl/pcs100_tx_encoder.sv
module pcs100_tx_encoder
  import pcs_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rmii_sel,
  input  logic             enc_en,
  input  logic             speed100,
  input  logic [NIB_W-1:0] mac_txd,
  input  logic             mac_txen,
  input  logic             mac_txer,
  output logic [SYM_W-1:0] sym,
  output logic             sym_vld
);
  logic [NIB_W-1:0] nib;
  logic             slot;
  logic             bypass;
  logic             err_eff;
  logic [SYM_W-1:0] raw;
  logic [SYM_W-1:0] sym_nxt;
  logic             frame_start;
  logic             frame_end;

  assign bypass  = ~enc_en & ~rmii_sel;
  assign err_eff = mac_txer & speed100 & ~rmii_sel;
  assign raw     = {mac_txer, mac_txd};

  pcs_tx_lane_pack #(.IN_W(LANE_W), .OUT_W(NIB_W)) i_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .narrow (rmii_sel),
    .din    (mac_txd),
    .word   (nib),
    .slot   (slot)
  );

  pcs_tx_framer i_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot        (slot),
    .bypass      (bypass),
    .en          (mac_txen),
    .err         (err_eff),
    .nib         (nib),
    .raw         (raw),
    .sym_nxt     (sym_nxt),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym     <= SYM_IDLE;
      sym_vld <= 1'b0;
    end else begin
      sym_vld <= slot;
      if (slot) sym <= sym_nxt;
    end
  end
endmodule

// File: rtl/pcs100_tx_encoder_chk.sv
module pcs100_tx_encoder_chk
  import pcs_tx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rmii_sel,
  input logic             enc_en,
  input logic [NIB_W-1:0] mac_txd,
  input logic             mac_txer,
  input logic [SYM_W-1:0] sym,
  input logic             sym_vld,
  input logic             frame_start,
  input logic             frame_end
);
  logic rst_d = 1'b0;
  always @(posedge clk) rst_d <= !rst_n;

  // R1
  always @(posedge clk)
    if (rst_d) reset_idle_chk: assert (sym == SYM_IDLE && !sym_vld);

  // R2
  nibble_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rmii_sel |=> sym_vld);

  // R7
  reduced_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmii_sel && $past(rmii_sel) |-> !(sym_vld && $past(sym_vld)));

  // R4
  start_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> sym == SYM_J && sym_vld);

  // R5
  end_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> sym == SYM_T && sym_vld);

  // R9
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rmii_sel && !enc_en |=> sym == $past({mac_txer, mac_txd}));
endmodule

bind pcs100_tx_encoder pcs100_tx_encoder_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rmii_sel    (rmii_sel),
  .enc_en      (enc_en),
  .mac_txd     (mac_txd),
  .mac_txer    (mac_txer),
  .sym         (sym),
  .sym_vld     (sym_vld),
  .frame_start (frame_start),
  .frame_end   (frame_end)
);

// File: tb/test_pcs100_tx_encoder.sv
module test_pcs100_tx_encoder;
  localparam logic [4:0] IDLE = 5'b11111, J = 5'b11000, K = 5'b10001,
                         T = 5'b01101, R = 5'b00111, H = 5'b00100;
  localparam logic [79:0] CODE_TAB = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rmii_sel = 1'b0;
  logic       enc_en = 1'b1;
  logic       speed100 = 1'b1;
  logic [3:0] txd = 4'h0;
  logic       txen = 1'b0;
  logic       txer = 1'b0;
  logic [4:0] sym;
  logic       sym_vld;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcs100_tx_encoder i_pcs100_tx_encoder (
    .clk(clk), .rst_n(rst_n), .rmii_sel(rmii_sel), .enc_en(enc_en),
    .speed100(speed100), .mac_txd(txd), .mac_txen(txen), .mac_txer(txer),
    .sym(sym), .sym_vld(sym_vld));

  function automatic logic [4:0] code(input logic [3:0] n);
    return CODE_TAB[int'(n)*5 +: 5];
  endfunction

  task automatic chk5(input string req, input logic [4:0] act, input logic [4:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: sym=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: sym_vld=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk5("R1", sym, IDLE);
    chk1("R1", sym_vld, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic nib_slot(input logic en, input logic [3:0] d, input logic er,
                          input logic [4:0] exp, input string req);
    txen = en; txd = d; txer = er;
    @(negedge clk);
    chk5(req, sym, exp);
    chk1("R2", sym_vld, 1'b1);
  endtask

  task automatic red_slot(input logic en, input logic [3:0] n, input logic [1:0] junk,
                          input logic er, input logic [4:0] exp, input string req);
    txen = en; txd = {junk, n[1:0]}; txer = er;
    @(negedge clk);
    chk1("R7", sym_vld, 1'b0);
    txd = {~junk, n[3:2]};
    @(negedge clk);
    chk5(req, sym, exp);
    chk1("R7", sym_vld, 1'b1);
  endtask

  task automatic test_reset_idle();
    rmii_sel = 1'b0; enc_en = 1'b1;
    do_reset();
    for (int i = 0; i < 3; i++) nib_slot(1'b0, 4'hA, 1'b0, IDLE, "R2");
  endtask

  task automatic test_nibble_frame();
    nib_slot(1'b1, 4'h5, 1'b0, J, "R4");
    nib_slot(1'b1, 4'h5, 1'b0, K, "R4");
    for (int n = 0; n < 16; n++) nib_slot(1'b1, 4'(n), 1'b0, code(4'(n)), "R3");
    nib_slot(1'b0, 4'h0, 1'b0, T, "R5");
    nib_slot(1'b0, 4'h0, 1'b0, R, "R5");
    nib_slot(1'b0, 4'h0, 1'b0, IDLE, "R5");
  endtask

  task automatic test_short_frames();
    nib_slot(1'b1, 4'h5, 1'b0, J, "R5");
    nib_slot(1'b0, 4'h0, 1'b0, K, "R5");
    nib_slot(1'b0, 4'h0, 1'b0, T, "R5");
    nib_slot(1'b1, 4'h5, 1'b0, R, "R5");
    nib_slot(1'b1, 4'h5, 1'b0, J, "R5");
    nib_slot(1'b1, 4'h5, 1'b0, K, "R5");
    nib_slot(1'b1, 4'h3, 1'b0, code(4'h3), "R5");
    nib_slot(1'b0, 4'h0, 1'b0, T, "R5");
    nib_slot(1'b0, 4'h0, 1'b0, R, "R5");
    nib_slot(1'b0, 4'h0, 1'b0, IDLE, "R5");
  endtask

  task automatic test_error();
    for (int s = 1; s >= 0; s--) begin
      speed100 = s[0];
      nib_slot(1'b1, 4'h5, 1'b0, J, "R6");
      nib_slot(1'b1, 4'h5, 1'b0, K, "R6");
      nib_slot(1'b1, 4'h7, 1'b1, s[0] ? H : code(4'h7), "R6");
      nib_slot(1'b1, 4'h7, 1'b0, code(4'h7), "R6");
      nib_slot(1'b0, 4'h0, 1'b0, T, "R6");
      nib_slot(1'b0, 4'h0, 1'b0, R, "R6");
    end
    speed100 = 1'b1;
  endtask

  task automatic test_bypass();
    enc_en = 1'b0;
    nib_slot(1'b1, 4'h2, 1'b1, 5'b10010, "R9");
    nib_slot(1'b1, 4'hF, 1'b0, 5'b01111, "R9");
    nib_slot(1'b0, 4'h0, 1'b0, 5'b00000, "R9");
    nib_slot(1'b0, 4'hC, 1'b1, 5'b11100, "R9");
    nib_slot(1'b1, 4'h9, 1'b1, 5'b11001, "R9");
    enc_en = 1'b1;
    nib_slot(1'b0, 4'h9, 1'b0, IDLE, "R9");
  endtask

  task automatic test_reduced();
    rmii_sel = 1'b1; enc_en = 1'b0;
    // R10: bypass request ignored in reduced mode
    do_reset();
    red_slot(1'b0, 4'h0, 2'b10, 1'b0, IDLE, "R7");
    red_slot(1'b1, 4'h5, 2'b11, 1'b0, J, "R10");
    red_slot(1'b1, 4'h5, 2'b01, 1'b0, K, "R10");
    red_slot(1'b1, 4'h9, 2'b11, 1'b1, code(4'h9), "R7");
    red_slot(1'b1, 4'hE, 2'b10, 1'b1, code(4'hE), "R7");
    red_slot(1'b1, 4'h6, 2'b00, 1'b0, code(4'h6), "R10");
    red_slot(1'b0, 4'h0, 2'b11, 1'b0, T, "R7");
    red_slot(1'b0, 4'h0, 2'b11, 1'b0, R, "R7");
    red_slot(1'b0, 4'h0, 2'b00, 1'b0, IDLE, "R7");
  endtask

  task automatic test_reset_mid_pair();
    txen = 1'b1; txd = 4'b0011;
    @(negedge clk);
    do_reset();
    // R8: pairing must restart at the first dibit after reset
    red_slot(1'b1, 4'h5, 2'b00, 1'b0, J, "R8");
    red_slot(1'b1, 4'h5, 2'b00, 1'b0, K, "R8");
    red_slot(1'b1, 4'hB, 2'b00, 1'b0, code(4'hB), "R8");
    red_slot(1'b1, 4'h1, 2'b00, 1'b0, code(4'h1), "R8");
    red_slot(1'b0, 4'h0, 2'b00, 1'b0, T, "R8");
    red_slot(1'b0, 4'h0, 2'b00, 1'b0, R, "R8");
    rmii_sel = 1'b0; enc_en = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    test_reset_idle();
    test_nibble_frame();
    test_short_frames();
    test_error();
    test_bypass();
    test_reduced();
    test_reset_mid_pair();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    finish_run();
  end
endmodule